// File: doc/BRIEF.md
# LPC I/O Target

This block is the target side of Low Pin Count bus I/O cycles. It watches the active-low frame strobe and the 4-bit multiplexed LAD bus. It recognises a cycle start and decodes the cycle type, which gives the direction. It then collects a 16-bit I/O address and compares it against a programmable base window. On a match it carries exactly one data byte between the bus and a small local register port. It drives the SYNC handshake, with wait states, and hands the bus back with a turnaround. Any wider access must be split by the host into byte cycles.

On the local side, the block issues a one-clock read or write strobe together with the address and, for writes, the data. It then holds the bus in wait SYNC until the local logic answers on a ready input or an error input. It never requests DMA, so its request line stays inactive. Addresses outside the window, unsupported cycle types, an abort by the host and reset all leave the LAD bus undriven.

Top module: `lpc_io_target`

## Requirements
- R1: While `rst_n` is low, `lad_oe` is 0, no local strobe is issued and `frame_n` has no effect. `dreq_n` reads 1 at all times.
- R2: A cycle begins on the last clock with `frame_n` low and LAD = 0000. The next nibble selects the cycle type: 0000 is an I/O read and 0010 is an I/O write. Any other type is ignored and LAD is never driven.
- R3: The address is taken from the four nibbles that follow the type, most significant nibble first. The access hits when address bits [15:WIN_BITS] equal `cfg_base` bits [15:WIN_BITS]. On a miss, LAD stays undriven and no strobe is issued until the next start.
- R4: On a write hit, the two data nibbles arrive low nibble first. After the two-clock host turnaround, `loc_wr` pulses for exactly one clock with `loc_addr` and `loc_wdata` valid.
- R5: On a read hit, `loc_rd` pulses for exactly one clock after the host turnaround. The captured byte is driven after the completion SYNC, low nibble first.
- R6: The first target-driven clock is always the short-wait SYNC 0101, and it is driven in the same clock as the strobe. Wait SYNC continues every clock in which neither `loc_ready` nor `loc_err` is high.
- R7: After LONG_WAIT wait clocks without an answer, the wait code becomes the long-wait SYNC 0110 and stays there.
- R8: The clock after `loc_ready` is sampled high drives SYNC 0000 for one clock. The clock after `loc_err` is sampled high drives SYNC 1010, and the error takes priority over ready. A read that ends in error returns the byte 0xFF.
- R9: After the last target nibble, the target drives 1111 for one clock, then releases LAD and returns to idle.
- R10: `frame_n` low in the middle of a cycle aborts it. LAD is released from the next clock, and a new start is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the LAD bus |
| lad_out | output | 4 | Nibble driven onto LAD when enabled |
| lad_oe | output | 1 | LAD output enable |
| dreq_n | output | 1 | Active-low DMA request, held inactive |
| cfg_base | input | 16 | Base address of the decode window |
| loc_rd | output | 1 | One-clock local read strobe |
| loc_wr | output | 1 | One-clock local write strobe |
| loc_addr | output | 16 | Address of the current access |
| loc_wdata | output | 8 | Write byte for the local port |
| loc_rdata | input | 8 | Read byte from the local port |
| loc_ready | input | 1 | Local access completed without error |
| loc_err | input | 1 | Local access faulted |

## Verification
A wrong phase state or nibble counter shows up on LAD within one or two clocks. It appears as a SYNC code in the wrong clock, a data nibble order that is swapped, or a turnaround that is missing or one clock late. A bad address latch or compare shows up as a strobe with the wrong address, or as LAD driven on a miss, before the first SYNC clock. A stale wait counter shows up as 0110 too early or too late. A lost abort shows up as `lad_oe` still high the clock after `frame_n` falls.

// File: rtl/lpc_io_pkg.sv
// Shared constants and phase encoding for the LPC I/O target.
// Assumes a 4-bit LAD bus, 16-bit I/O addresses and byte-wide data.
package lpc_io_pkg;

    localparam int NIB_W  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [NIB_W-1:0] NIB_START  = 4'b0000;
    localparam logic [NIB_W-1:0] CT_IO_RD   = 4'b0000;
    localparam logic [NIB_W-1:0] CT_IO_WR   = 4'b0010;
    localparam logic [NIB_W-1:0] SYNC_OK    = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_SHORT = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_LONG  = 4'b0110;
    localparam logic [NIB_W-1:0] SYNC_ERR   = 4'b1010;
    localparam logic [NIB_W-1:0] NIB_TAR    = 4'b1111;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CTYP,
        PH_ADDR,
        PH_WDAT,
        PH_HTAR,
        PH_SYNC,
        PH_SFIN,
        PH_RDAT,
        PH_TTAR,
        PH_SKIP
    } lpc_phase_e;

endpackage

// File: rtl/lpc_io_collect.sv
// Nibble collector: shifts address nibbles in most significant first and
// data nibbles in least significant first.
// Assumes the controller raises exactly one enable per nibble clock.
module lpc_io_collect #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_en,
    input  logic          data_en,
    input  logic [NW-1:0] nib,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    // Address shift register, new nibble enters at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_en) begin
            addr_q <= {addr_q[AW-NW-1:0], nib};
        end
    end

    // Data shift register, new nibble enters at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_en) begin
            data_q <= {nib, data_q[DW-1:NW]};
        end
    end

endmodule

// File: rtl/lpc_io_sync_gen.sv
// Wait-code generator: counts clocks spent in wait SYNC and selects the
// short or long wait code. Assumes active is high only during wait SYNC.
module lpc_io_sync_gen
    import lpc_io_pkg::*;
#(
    parameter int LONG_WAIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    output logic [NIB_W-1:0] wait_code
);

    localparam int CW = $clog2(LONG_WAIT + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(LONG_WAIT);

    logic [CW-1:0] cnt_q;

    // Saturating count of wait clocks, cleared outside wait SYNC.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wait_code = (cnt_q == CNT_TOP) ? SYNC_LONG : SYNC_SHORT;

endmodule

// File: rtl/lpc_io_lad_mux.sv
// LAD drive selector: chooses the nibble and the enable for the current
// phase. Pure decode of registered state, no storage.
module lpc_io_lad_mux
    import lpc_io_pkg::*;
(
    input  lpc_phase_e        phase,
    input  logic              idx0,
    input  logic              err,
    input  logic [DATA_W-1:0] rdata,
    input  logic [NIB_W-1:0]  wait_code,
    output logic [NIB_W-1:0]  drv_nib,
    output logic              drv_en
);

    // Phase-to-nibble decode.
    always_comb begin
        drv_nib = NIB_TAR;
        drv_en  = 1'b0;
        unique case (phase)
            PH_SYNC: begin
                drv_nib = wait_code;
                drv_en  = 1'b1;
            end
            PH_SFIN: begin
                drv_nib = err ? SYNC_ERR : SYNC_OK;
                drv_en  = 1'b1;
            end
            PH_RDAT: begin
                drv_nib = idx0 ? rdata[DATA_W-1:NIB_W] : rdata[NIB_W-1:0];
                drv_en  = 1'b1;
            end
            PH_TTAR: begin
                drv_nib = NIB_TAR;
                drv_en  = !idx0;
            end
            default: begin
                drv_nib = NIB_TAR;
                drv_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_io_target.sv
// LPC I/O target: decodes single-byte I/O read and write cycles aimed at a
// base window, runs the local port handshake, drives SYNC and turnarounds.
// Assumes frame_n and lad_in are synchronous to clk; reset is synchronous
// and active low; the LAD enable is also gated directly by reset.
module lpc_io_target
    import lpc_io_pkg::*;
#(
    parameter int WIN_BITS  = 3,
    parameter int LONG_WAIT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic        dreq_n,
    input  logic [15:0] cfg_base,
    output logic        loc_rd,
    output logic        loc_wr,
    output logic [15:0] loc_addr,
    output logic [7:0]  loc_wdata,
    input  logic [7:0]  loc_rdata,
    input  logic        loc_ready,
    input  logic        loc_err
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int IDX_W     = $clog2(ADDR_NIBS);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_NIBS - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_NIBS - 1);
    localparam logic [IDX_W-1:0] TAR_LAST  = IDX_W'(1);
    localparam logic [ADDR_W-1:0] HIT_MASK = {ADDR_W{1'b1}} << WIN_BITS;

    lpc_phase_e        phase_q, phase_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              is_wr_q, is_wr_d;
    logic              err_q, err_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_full;
    logic [DATA_W-1:0] wdata_q;
    logic              addr_hit;
    logic              enter_sync;
    logic              sync_phase;
    logic [NIB_W-1:0]  wait_code;
    logic [NIB_W-1:0]  drv_nib;
    logic              drv_en;

    assign addr_full  = {addr_q[ADDR_W-NIB_W-1:0], lad_in};
    assign addr_hit   = ((addr_full ^ cfg_base) & HIT_MASK) == '0;
    assign enter_sync = frame_n && (phase_q == PH_HTAR) && (idx_q == TAR_LAST);
    assign sync_phase = (phase_q == PH_SYNC);

    lpc_io_collect #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .NW (NIB_W)
    ) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_en (frame_n && (phase_q == PH_ADDR)),
        .data_en (frame_n && (phase_q == PH_WDAT)),
        .nib     (lad_in),
        .addr_q  (addr_q),
        .data_q  (wdata_q)
    );

    lpc_io_sync_gen #(
        .LONG_WAIT (LONG_WAIT)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (sync_phase),
        .wait_code (wait_code)
    );

    lpc_io_lad_mux u_mux (
        .phase     (phase_q),
        .idx0      (idx_q[0]),
        .err       (err_q),
        .rdata     (rdata_q),
        .wait_code (wait_code),
        .drv_nib   (drv_nib),
        .drv_en    (drv_en)
    );

    // Next-phase logic; a low frame always restarts or aborts.
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        is_wr_d = is_wr_q;
        err_d   = err_q;
        rdata_d = rdata_q;
        if (!frame_n) begin
            phase_d = (lad_in == NIB_START) ? PH_CTYP : PH_IDLE;
            idx_d   = '0;
        end else begin
            unique case (phase_q)
                PH_CTYP: begin
                    if (lad_in == CT_IO_RD) begin
                        phase_d = PH_ADDR;
                        is_wr_d = 1'b0;
                    end else if (lad_in == CT_IO_WR) begin
                        phase_d = PH_ADDR;
                        is_wr_d = 1'b1;
                    end else begin
                        phase_d = PH_SKIP;
                    end
                end
                PH_ADDR: begin
                    if (idx_q == ADDR_LAST) begin
                        idx_d = '0;
                        if (!addr_hit)    phase_d = PH_SKIP;
                        else if (is_wr_q) phase_d = PH_WDAT;
                        else              phase_d = PH_HTAR;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                PH_WDAT: begin
                    if (idx_q == DATA_LAST) begin
                        idx_d   = '0;
                        phase_d = PH_HTAR;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                PH_HTAR: begin
                    if (idx_q == TAR_LAST) begin
                        idx_d   = '0;
                        phase_d = PH_SYNC;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                PH_SYNC: begin
                    if (loc_ready || loc_err) begin
                        phase_d = PH_SFIN;
                        err_d   = loc_err;
                        rdata_d = loc_err ? {DATA_W{1'b1}} : loc_rdata;
                    end
                end
                PH_SFIN: begin
                    idx_d   = '0;
                    phase_d = is_wr_q ? PH_TTAR : PH_RDAT;
                end
                PH_RDAT: begin
                    if (idx_q == DATA_LAST) begin
                        idx_d   = '0;
                        phase_d = PH_TTAR;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                PH_TTAR: begin
                    if (idx_q == TAR_LAST) begin
                        idx_d   = '0;
                        phase_d = PH_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                default: begin
                    phase_d = phase_q;
                end
            endcase
        end
    end

    // Phase, counter and captured-result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            is_wr_q <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            is_wr_q <= is_wr_d;
            err_q   <= err_d;
            rdata_q <= rdata_d;
        end
    end

    // One-clock local strobes, raised together with the first wait SYNC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_rd <= 1'b0;
            loc_wr <= 1'b0;
        end else begin
            loc_rd <= enter_sync && !is_wr_q;
            loc_wr <= enter_sync && is_wr_q;
        end
    end

    assign loc_addr  = addr_q;
    assign loc_wdata = wdata_q;
    assign lad_out   = drv_nib;
    assign lad_oe    = rst_n && drv_en;
    assign dreq_n    = 1'b1;

endmodule

// File: rtl/lpc_io_target_chk.sv
// Protocol checker for the LPC I/O target, attached by bind below.
// Observes ports plus the wait-phase flag of the controller.
module lpc_io_target_chk
    import lpc_io_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       dreq_n,
    input logic       loc_rd,
    input logic       loc_wr,
    input logic       loc_ready,
    input logic       loc_err,
    input logic       sync_active
);

    // Held in reset: bus released, no DMA request.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!lad_oe && dreq_n));

    // Write strobe lasts a single clock.
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr |=> !loc_wr);

    // Read strobe lasts a single clock and never pairs with a write.
    assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd |=> !loc_rd);

    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_rd && loc_wr));

    // Strobe clock is always a short-wait SYNC clock.
    assert_min_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd || loc_wr) |-> (lad_oe && lad_out == SYNC_SHORT));

    // Ready without error gives the OK code next clock.
    assert_ready_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && frame_n && loc_ready && !loc_err) |=>
            (lad_oe && lad_out == SYNC_OK));

    // Error gives the error code next clock.
    assert_error_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && frame_n && loc_err) |=>
            (lad_oe && lad_out == SYNC_ERR));

    // Release after a normal end is always preceded by a 1111 clock.
    assert_tar_before_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lad_oe) && $past(frame_n)) |-> ($past(lad_out) == NIB_TAR));

    // Frame low while driving releases the bus next clock.
    assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && lad_oe) |=> !lad_oe);

endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .lad_out     (lad_out),
    .lad_oe      (lad_oe),
    .dreq_n      (dreq_n),
    .loc_rd      (loc_rd),
    .loc_wr      (loc_wr),
    .loc_ready   (loc_ready),
    .loc_err     (loc_err),
    .sync_active (sync_phase)
);

// File: tb/lpc_io_target_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: a host-model driver runs bus cycles and queues the
// expected local strobes; a monitor pops and compares them and answers
// as the local register port.
module lpc_io_target_bench;

    localparam int LONG_WAIT = 4;
    localparam logic [15:0] BASE = 16'h02F8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_frame = 1'b1;
    logic [3:0]  host_lad = 4'hF;
    logic        host_oe = 1'b0;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        dreq_n;
    logic        loc_rd;
    logic        loc_wr;
    logic [15:0] loc_addr;
    logic [7:0]  loc_wdata;
    logic        loc_ready = 1'b0;
    logic        loc_err = 1'b0;
    logic [3:0]  lad_bus;

    logic [7:0]  loc_mem [16];
    logic [7:0]  exp_mem [16];
    logic [24:0] sb_q [$];
    int          checks = 0;
    int          errors = 0;
    int          rsp_delay = 0;
    bit          rsp_err = 1'b0;

    assign lad_bus = host_oe ? host_lad : (lad_oe ? lad_out : 4'hF);

    always #10 clk = ~clk;

    lpc_io_target #(
        .WIN_BITS  (3),
        .LONG_WAIT (LONG_WAIT)
    ) u_lpc_io_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (host_frame),
        .lad_in    (lad_bus),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .dreq_n    (dreq_n),
        .cfg_base  (BASE),
        .loc_rd    (loc_rd),
        .loc_wr    (loc_wr),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_mem[loc_addr[3:0]]),
        .loc_ready (loc_ready),
        .loc_err   (loc_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive bus inputs at a falling edge and wait one full clock.
    task automatic bus_step(input logic f, input logic [3:0] v, input logic oe);
        host_frame = f;
        host_lad   = v;
        host_oe    = oe;
        @(negedge clk);
    endtask

    function automatic logic [3:0] wait_nib(input int i);
        return (i < LONG_WAIT) ? 4'h5 : 4'h6;
    endfunction

    // Full host cycle up to and including bus release.
    task automatic io_cycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                            input bit hit, input int dly, input bit err);
        logic [7:0] rexp;
        if (hit) begin
            rsp_delay = dly;
            rsp_err   = err;
            sb_q.push_back({wr, a, d});
        end
        rexp = err ? 8'hFF : exp_mem[a[3:0]];
        if (hit && wr) exp_mem[a[3:0]] = d;
        bus_step(1'b0, 4'h0, 1'b1);
        bus_step(1'b1, wr ? 4'h2 : 4'h0, 1'b1);
        for (int i = 3; i >= 0; i--) bus_step(1'b1, a[i*4 +: 4], 1'b1);
        if (wr) begin
            bus_step(1'b1, d[3:0], 1'b1);
            bus_step(1'b1, d[7:4], 1'b1);
        end
        bus_step(1'b1, 4'hF, 1'b1);
        bus_step(1'b1, 4'hF, 1'b0);
        if (!hit) begin
            for (int i = 0; i < 8; i++) begin
                chk("R3 miss leaves LAD undriven", lad_oe, 0);
                bus_step(1'b1, 4'hF, 1'b0);
            end
            return;
        end
        for (int i = 0; i <= dly; i++) begin
            chk("R6 R7 wait SYNC", {lad_oe, lad_out}, {1'b1, wait_nib(i)});
            bus_step(1'b1, 4'hF, 1'b0);
        end
        chk("R8 completion SYNC", {lad_oe, lad_out}, {1'b1, err ? 4'hA : 4'h0});
        bus_step(1'b1, 4'hF, 1'b0);
        if (!wr) begin
            chk("R5 read low nibble", {lad_oe, lad_out}, {1'b1, rexp[3:0]});
            bus_step(1'b1, 4'hF, 1'b0);
            chk("R5 read high nibble", {lad_oe, lad_out}, {1'b1, rexp[7:4]});
            bus_step(1'b1, 4'hF, 1'b0);
        end
        chk("R9 turnaround 1111", {lad_oe, lad_out}, {1'b1, 4'hF});
        bus_step(1'b1, 4'hF, 1'b0);
        chk("R9 bus released", lad_oe, 0);
        bus_step(1'b1, 4'hF, 1'b0);
    endtask

    // Monitor and local responder: compare strobes, then answer after delay.
    initial begin
        int          cnt;
        bit          pend;
        logic [24:0] item;
        cnt  = 0;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            loc_ready = 1'b0;
            loc_err   = 1'b0;
            if (rst_n && (loc_wr || loc_rd)) begin
                if (sb_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 R5 unexpected strobe actual=%0h expected=none", loc_addr);
                end else begin
                    item = sb_q.pop_front();
                    chk("R4 R5 strobe kind", loc_wr, item[24]);
                    chk("R3 local address", loc_addr, item[23:8]);
                    if (loc_wr) chk("R4 write byte", loc_wdata, item[7:0]);
                end
                if (loc_wr) loc_mem[loc_addr[3:0]] = loc_wdata;
                pend = 1'b1;
                cnt  = rsp_delay;
            end
            if (pend) begin
                if (cnt == 0) begin
                    pend = 1'b0;
                    if (rsp_err) loc_err = 1'b1;
                    else         loc_ready = 1'b1;
                end else begin
                    cnt--;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            loc_mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        // R1: reset state, frame activity ignored
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            bus_step(1'b0, 4'h0, 1'b1);
            chk("R1 reset LAD released", lad_oe, 0);
            chk("R1 reset no DMA request", dreq_n, 1);
            chk("R1 reset no strobe", {loc_rd, loc_wr}, 0);
        end
        rst_n = 1'b1;
        bus_step(1'b1, 4'hF, 1'b0);
        bus_step(1'b1, 4'hF, 1'b0);

        // R2 R4 R5: basic write then read, one wait clock
        io_cycle(1'b1, 16'h02F9, 8'hA5, 1'b1, 0, 1'b0);
        io_cycle(1'b0, 16'h02F9, 8'h00, 1'b1, 0, 1'b0);
        // R6 R7: longer waits, long code after LONG_WAIT clocks
        io_cycle(1'b1, 16'h02FE, 8'h3C, 1'b1, 2, 1'b0);
        io_cycle(1'b0, 16'h02FE, 8'h00, 1'b1, 5, 1'b0);
        io_cycle(1'b0, 16'h02F8, 8'h00, 1'b1, 3, 1'b0);
        // R8: error completion on write and read
        io_cycle(1'b1, 16'h02FB, 8'h77, 1'b1, 1, 1'b1);
        io_cycle(1'b0, 16'h02FB, 8'h00, 1'b1, 0, 1'b1);
        io_cycle(1'b0, 16'h02FB, 8'h00, 1'b1, 0, 1'b0);
        // R3: misses above and below the window
        io_cycle(1'b1, 16'h03F9, 8'h11, 1'b0, 0, 1'b0);
        io_cycle(1'b0, 16'h02F0, 8'h00, 1'b0, 0, 1'b0);
        io_cycle(1'b0, 16'h02F9, 8'h00, 1'b1, 0, 1'b0);

        // R2: unsupported cycle type is ignored
        bus_step(1'b0, 4'h0, 1'b1);
        bus_step(1'b1, 4'h4, 1'b1);
        for (int i = 0; i < 8; i++) begin
            bus_step(1'b1, 4'hF, (i < 6));
            chk("R2 other type not driven", lad_oe, 0);
        end

        // R10: abort during address phase
        bus_step(1'b0, 4'h0, 1'b1);
        bus_step(1'b1, 4'h2, 1'b1);
        bus_step(1'b1, 4'h0, 1'b1);
        bus_step(1'b1, 4'h2, 1'b1);
        bus_step(1'b0, 4'hF, 1'b1);
        bus_step(1'b0, 4'hF, 1'b1);
        for (int i = 0; i < 6; i++) begin
            chk("R10 abort in address", lad_oe, 0);
            bus_step(1'b1, 4'hF, 1'b0);
        end

        // R10: abort while target drives wait SYNC
        rsp_delay = 6;
        rsp_err   = 1'b0;
        sb_q.push_back({1'b0, 16'h02FA, 8'h00});
        bus_step(1'b0, 4'h0, 1'b1);
        bus_step(1'b1, 4'h0, 1'b1);
        bus_step(1'b1, 4'h0, 1'b1);
        bus_step(1'b1, 4'h2, 1'b1);
        bus_step(1'b1, 4'hF, 1'b1);
        bus_step(1'b1, 4'hA, 1'b1);
        bus_step(1'b1, 4'hF, 1'b1);
        bus_step(1'b1, 4'hF, 1'b0);
        chk("R6 first SYNC before abort", {lad_oe, lad_out}, {1'b1, 4'h5});
        bus_step(1'b0, 4'hF, 1'b1);
        chk("R10 abort releases LAD", lad_oe, 0);
        for (int i = 0; i < 10; i++) begin
            bus_step(1'b1, 4'hF, 1'b0);
            chk("R10 stays released", lad_oe, 0);
        end
        io_cycle(1'b0, 16'h02FE, 8'h00, 1'b1, 0, 1'b0);

        // R1: reset in the middle of wait SYNC
        rsp_delay = 8;
        sb_q.push_back({1'b0, 16'h02F9, 8'h00});
        bus_step(1'b0, 4'h0, 1'b1);
        bus_step(1'b1, 4'h0, 1'b1);
        bus_step(1'b1, 4'h0, 1'b1);
        bus_step(1'b1, 4'h2, 1'b1);
        bus_step(1'b1, 4'hF, 1'b1);
        bus_step(1'b1, 4'h9, 1'b1);
        bus_step(1'b1, 4'hF, 1'b1);
        bus_step(1'b1, 4'hF, 1'b0);
        chk("R6 SYNC before reset", {lad_oe, lad_out}, {1'b1, 4'h5});
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bus_step(1'b0, 4'h0, 1'b1);
            chk("R1 mid-cycle reset releases LAD", lad_oe, 0);
            chk("R1 DMA request inactive", dreq_n, 1);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            bus_step(1'b1, 4'hF, 1'b0);
            chk("R1 idle after reset", lad_oe, 0);
        end
        io_cycle(1'b0, 16'h02F9, 8'h00, 1'b1, 1, 1'b0);

        chk("R4 R5 scoreboard drained", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule